// File: doc/BRIEF.md
# Conversion Ready Flag Controller

This block starts conversions and keeps the ready flag for a sensor converter. A configuration write sets the operating mode (single-shot or continuous), two stored but uninterpreted setting fields (sample rate and gain), and a request bit. The request bit asks for a new conversion. The block issues a one-cycle start request to the converter. It latches each result the converter reports and keeps an active-low ready flag, so a bus interface can read the result back and see the flag.

The flag is low when an unread result is waiting. What happens after a read depends on the mode. In single-shot mode the flag stays low until software asks for another conversion. In continuous mode the flag goes high again after the read and stays high until the next result arrives. In continuous mode the block also restarts the converter by itself after every completed conversion. The analog conversion is outside this block. The converter is expected to return a done pulse, together with the result word, some fixed number of cycles after each start request.

Top module: `conv_ready_ctrl`

## Requirements
- R1: After reset, `startReq` is 0, `modeOut` is 0 (single-shot), `rdyOut` is 1, `resultOut` is 0, and `rateOut` and `gainOut` are 0.
- R2: A write with `cfgRdy`=1 and `cfgMode`=0 sets `startReq` to 1 for exactly the one cycle after the write. It also sets `rdyOut` to 1 and `modeOut` to 0 from that cycle on.
- R3: A write with `cfgRdy`=1 and `cfgMode`=1 (continuous) sets `startReq` to 1 for the one cycle after the write, and sets `modeOut` to 1 and `rdyOut` to 1.
- R4: In single-shot mode, `rdyOut` stays 1 while the conversion is outstanding. No start request follows the done pulse.
- R5: In single-shot mode, a result read leaves `rdyOut` at 0. It stays 0 until a write with `cfgRdy`=1.
- R6: A write with `cfgRdy`=0 produces no start request and leaves `rdyOut` unchanged.
- R7: A `convDone` pulse sets `rdyOut` to 0 in the next cycle.
- R8: In continuous mode, a result read sets `rdyOut` to 1 in the next cycle. It stays 1 until the next `convDone`.
- R9: In continuous mode, `startReq` is 1 in the cycle after each `convDone` pulse.
- R10: Every `convDone` copies `convResult` into `resultOut`, visible in the next cycle. This happens whether or not the previous result was read.
- R11: Every write, whatever the value of `cfgRdy`, updates `modeOut`, `rateOut` and `gainOut` in the next cycle. The new mode governs the next done pulse and the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgMode | input | 1 | Mode in the write: 1 continuous, 0 single-shot |
| cfgRdy | input | 1 | Request bit in the write: 1 requests a conversion |
| cfgRate | input | RATE_W | Rate field, stored only |
| cfgGain | input | GAIN_W | Gain field, stored only |
| convDone | input | 1 | Conversion-complete pulse from the converter |
| convResult | input | RESULT_W | Result word valid with `convDone` |
| resultRead | input | 1 | Strobe from the bus interface: result was read |
| startReq | output | 1 | One-cycle start-conversion request |
| resultOut | output | RESULT_W | Latched result register |
| modeOut | output | 1 | Current mode bit |
| rdyOut | output | 1 | Active-low ready flag |
| rateOut | output | RATE_W | Stored rate field |
| gainOut | output | GAIN_W | Stored gain field |

## Verification
Every result of this block is registered once. A write, a done pulse or a read that is sampled at one rising edge shows on `startReq`, `rdyOut`, `resultOut` and the mode and field outputs just after that edge, and at no other time. The bench drives each stimulus for exactly one cycle. It then waits one edge and samples a nanosecond later, and it checks the cycle after that too, so that a start request lasting more than one cycle is caught. The hold conditions (the flag staying high during a single-shot conversion, and staying low after a single-shot read) are checked over several idle cycles.

// File: rtl/cvr_pkg.sv
package cvr_pkg;

  // Strobes passed from the control to the datapath each cycle.
  typedef struct packed {
    logic loadCfg;      // capture rate/gain fields
    logic latchResult;  // capture converter result
  } cvrStrobes_t;

endpackage

// File: rtl/cvr_ctrl.sv
module cvr_ctrl
  import cvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgMode,
  input  logic        cfgRdy,
  input  logic        convDone,
  input  logic        resultRead,
  output cvrStrobes_t strobes,
  output logic        startReq,
  output logic        modeOut,
  output logic        rdyOut
);

  logic modeQ;
  logic rdyQ;
  logic startQ;
  logic cfgStart;
  logic autoRestart;
  logic rdyNext;

  // A write with the request bit set always starts a conversion.
  assign cfgStart    = cfgWrEn && cfgRdy;
  // Continuous mode restarts after each done pulse unless a write takes over.
  assign autoRestart = convDone && modeQ && !cfgWrEn;

  always_comb begin
    rdyNext = rdyQ;
    if (cfgStart) begin
      rdyNext = 1'b1;
    end else if (convDone) begin
      rdyNext = 1'b0;
    end else if (resultRead && modeQ) begin
      rdyNext = 1'b1;
    end
  end

  always_comb begin
    strobes.loadCfg     = cfgWrEn;
    strobes.latchResult = convDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= 1'b0;
      rdyQ   <= 1'b1;
      startQ <= 1'b0;
    end else begin
      if (cfgWrEn) begin
        modeQ <= cfgMode;
      end
      rdyQ   <= rdyNext;
      startQ <= cfgStart || autoRestart;
    end
  end

  assign startReq = startQ;
  assign modeOut  = modeQ;
  assign rdyOut   = rdyQ;

  AST_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgRdy |=> startReq && rdyOut && (modeOut == $past(cfgMode))); // R2
  AST_IDLE_WRITE_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && !cfgRdy |=> !startReq); // R6
  AST_DONE_CLEARS_RDY: assert property (@(posedge clk) disable iff (!rstN)
    convDone && !(cfgWrEn && cfgRdy) |=> !rdyOut); // R7
  AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    convDone && modeOut && !cfgWrEn |=> startReq); // R9
  AST_SINGLE_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    resultRead && !modeOut && !convDone && !cfgWrEn |=> $stable(rdyOut)); // R5
  AST_CONT_READ_SETS: assert property (@(posedge clk) disable iff (!rstN)
    resultRead && modeOut && !convDone && !cfgWrEn |=> rdyOut); // R8

endmodule

// File: rtl/cvr_datapath.sv
module cvr_datapath
  import cvr_pkg::*;
#(
  parameter int RESULT_W = 18,
  parameter int RATE_W   = 2,
  parameter int GAIN_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  cvrStrobes_t         strobes,
  input  logic [RATE_W-1:0]   cfgRate,
  input  logic [GAIN_W-1:0]   cfgGain,
  input  logic [RESULT_W-1:0] convResult,
  output logic [RESULT_W-1:0] resultOut,
  output logic [RATE_W-1:0]   rateOut,
  output logic [GAIN_W-1:0]   gainOut
);

  localparam int FIELDS_W = RATE_W + GAIN_W;

  logic [RESULT_W-1:0] resultQ;
  logic [FIELDS_W-1:0] fieldsQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      fieldsQ <= '0;
    end else begin
      if (strobes.latchResult) begin
        resultQ <= convResult;
      end
      if (strobes.loadCfg) begin
        fieldsQ <= {cfgRate, cfgGain};
      end
    end
  end

  assign resultOut = resultQ;
  assign rateOut   = fieldsQ[FIELDS_W-1:GAIN_W];
  assign gainOut   = fieldsQ[GAIN_W-1:0];

  AST_RESULT_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.latchResult |=> resultOut == $past(convResult)); // R10
  AST_FIELDS_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCfg |=> (rateOut == $past(cfgRate)) && (gainOut == $past(cfgGain))); // R11
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.latchResult |=> $stable(resultOut)); // R10

endmodule

// File: rtl/conv_ready_ctrl.sv
module conv_ready_ctrl
  import cvr_pkg::*;
#(
  parameter int RESULT_W = 18,
  parameter int RATE_W   = 2,
  parameter int GAIN_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic                cfgMode,
  input  logic                cfgRdy,
  input  logic [RATE_W-1:0]   cfgRate,
  input  logic [GAIN_W-1:0]   cfgGain,
  input  logic                convDone,
  input  logic [RESULT_W-1:0] convResult,
  input  logic                resultRead,
  output logic                startReq,
  output logic [RESULT_W-1:0] resultOut,
  output logic                modeOut,
  output logic                rdyOut,
  output logic [RATE_W-1:0]   rateOut,
  output logic [GAIN_W-1:0]   gainOut
);

  cvrStrobes_t strobes;

  cvr_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgMode    (cfgMode),
    .cfgRdy     (cfgRdy),
    .convDone   (convDone),
    .resultRead (resultRead),
    .strobes    (strobes),
    .startReq   (startReq),
    .modeOut    (modeOut),
    .rdyOut     (rdyOut)
  );

  cvr_datapath #(
    .RESULT_W (RESULT_W),
    .RATE_W   (RATE_W),
    .GAIN_W   (GAIN_W)
  ) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgRate    (cfgRate),
    .cfgGain    (cfgGain),
    .convResult (convResult),
    .resultOut  (resultOut),
    .rateOut    (rateOut),
    .gainOut    (gainOut)
  );

endmodule

// File: tb/conv_ready_ctrl_tb.sv
module conv_ready_ctrl_tb_top;

  localparam int RESULT_W = 18;
  localparam int RATE_W   = 2;
  localparam int GAIN_W   = 2;
  localparam int LATENCY  = 5;

  logic                clk = 1'b0;
  logic                rstN;
  logic                cfgWrEn, cfgMode, cfgRdy;
  logic [RATE_W-1:0]   cfgRate;
  logic [GAIN_W-1:0]   cfgGain;
  logic                convDone;
  logic [RESULT_W-1:0] convResult;
  logic                resultRead;
  logic                startReq, modeOut, rdyOut;
  logic [RESULT_W-1:0] resultOut;
  logic [RATE_W-1:0]   rateOut;
  logic [GAIN_W-1:0]   gainOut;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  conv_ready_ctrl #(.RESULT_W(RESULT_W), .RATE_W(RATE_W), .GAIN_W(GAIN_W)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode), .cfgRdy(cfgRdy),
    .cfgRate(cfgRate), .cfgGain(cfgGain), .convDone(convDone), .convResult(convResult),
    .resultRead(resultRead), .startReq(startReq), .resultOut(resultOut),
    .modeOut(modeOut), .rdyOut(rdyOut), .rateOut(rateOut), .gainOut(gainOut)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  task automatic doWrite(logic mode, logic rdy, logic [RATE_W-1:0] rate, logic [GAIN_W-1:0] gain);
    cfgWrEn = 1'b1; cfgMode = mode; cfgRdy = rdy; cfgRate = rate; cfgGain = gain;
    tick();
    cfgWrEn = 1'b0;
  endtask

  task automatic doDone(logic [RESULT_W-1:0] value);
    convDone = 1'b1; convResult = value;
    tick();
    convDone = 1'b0;
  endtask

  task automatic doRead();
    resultRead = 1'b1;
    tick();
    resultRead = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "startReq", startReq, 0);
    chk("R1", "modeOut", modeOut, 0);
    chk("R1", "rdyOut", rdyOut, 1);
    chk("R1", "resultOut", resultOut, 0);
    chk("R1", "rate/gain", {rateOut, gainOut}, 0);
  endtask

  task automatic testSingleShot();
    doWrite(1'b0, 1'b1, 2'd1, 2'd2);
    chk("R2", "startReq after write", startReq, 1);
    chk("R2", "rdyOut after write", rdyOut, 1);
    chk("R2", "modeOut", modeOut, 0);
    tick();
    chk("R2", "startReq one cycle only", startReq, 0);
    for (int i = 0; i < LATENCY; i++) begin
      tick();
      chk("R4", "rdyOut during conversion", rdyOut, 1);
    end
    doDone(18'h2ABCD);
    chk("R7", "rdyOut after done", rdyOut, 0);
    chk("R10", "resultOut", resultOut, 18'h2ABCD);
    chk("R4", "no restart in single-shot", startReq, 0);
    doRead();
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5", "rdyOut held low after read", rdyOut, 0);
    end
    doWrite(1'b0, 1'b0, 2'd1, 2'd2);
    chk("R6", "no start on rdy=0 write", startReq, 0);
    chk("R6", "rdyOut unchanged", rdyOut, 0);
    tick();
    chk("R6", "still no start", startReq, 0);
    doWrite(1'b0, 1'b1, 2'd1, 2'd2);
    chk("R5", "write rdy=1 raises flag", rdyOut, 1);
    chk("R2", "second single start", startReq, 1);
    tick();
    doDone(18'h00011);
  endtask

  task automatic testContinuous();
    doWrite(1'b1, 1'b1, 2'd3, 2'd0);
    chk("R3", "startReq continuous", startReq, 1);
    chk("R3", "modeOut", modeOut, 1);
    chk("R3", "rdyOut", rdyOut, 1);
    chk("R11", "rateOut", rateOut, 3);
    tick();
    chk("R3", "startReq one cycle", startReq, 0);
    for (int i = 0; i < LATENCY; i++) tick();
    doDone(18'h12345);
    chk("R9", "auto restart", startReq, 1);
    chk("R7", "rdyOut low", rdyOut, 0);
    tick();
    chk("R9", "restart one cycle", startReq, 0);
    doRead();
    chk("R8", "rdyOut high after read", rdyOut, 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R8", "rdyOut held high", rdyOut, 1);
    end
    doDone(18'h0AAAA);
    chk("R7", "rdyOut low again", rdyOut, 0);
    chk("R9", "second restart", startReq, 1);
    tick();
    doDone(18'h35555);
    chk("R10", "overwrite unread result", resultOut, 18'h35555);
    chk("R10", "flag still low", rdyOut, 0);
    doWrite(1'b1, 1'b0, 2'd3, 2'd1);
    chk("R6", "no start on rdy=0 in continuous", startReq, 0);
    chk("R11", "gain updated", gainOut, 1);
    chk("R11", "mode kept", modeOut, 1);
    doWrite(1'b0, 1'b0, 2'd0, 2'd1);
    chk("R11", "mode switched to single", modeOut, 0);
    chk("R11", "rate updated", rateOut, 0);
    doDone(18'h00F0F);
    chk("R11", "no restart under new mode", startReq, 0);
    chk("R10", "result latched", resultOut, 18'h00F0F);
    doRead();
    chk("R5", "single read keeps flag low", rdyOut, 0);
  endtask

  initial begin
    rstN = 1'b0; cfgWrEn = 1'b0; cfgMode = 1'b0; cfgRdy = 1'b0;
    cfgRate = '0; cfgGain = '0; convDone = 1'b0; convResult = '0; resultRead = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
    testReset();
    testSingleShot();
    testContinuous();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule